// File: doc/BRIEF.md
# Steered Access Sequencer

This block carries out one read or one write to a replicated register, aimed at a chosen group and instance. Several copies of such a register share a single bus address. A shared selector register decides which copy a unicast access reaches, and whether writes go to every copy (multicast). The block accepts one request at a time. It reads the selector and keeps the value it got. It then writes the selector with the steering fields replaced and performs the target access. Last, it writes the selector again so that the steering fields go back to their saved contents.

The multicast flag sits inside the field mask only when the request is a write. A write therefore reaches exactly one copy, and the multicast flag is restored afterwards. A read leaves the flag untouched. Reads always return one copy's value whatever the flag says, and leaving it alone keeps the hardware in multicast mode during the read. A read reports the word captured from the target. A write reports zero.

Top module: `steered_access_seq`

## Requirements
- R1: After reset, req_ready is 1, bus_valid is 0 and rsp_done is 0.
- R2: Each accepted request produces exactly four bus transfers in this order: a read of the selector address (default 16'h0FD0), a write of the selector, the target access at req_addr with the request's direction, and a second write of the selector.
- R3: The first selector write carries (saved & ~mask) | (group << 8) | (instance << 0). The group field is bits [11:8] and the instance field is bits [3:0]; both are always in the mask.
- R4: For a write request the mask also holds the multicast flag at bit 16, so that bit is 0 in the first selector write.
- R5: For a read request bit 16 is outside the mask and carries its saved value in the first selector write.
- R6: The final selector write puts the saved value into the masked fields and takes every other bit from the first selector write. The selector therefore ends the sequence equal to its value before it.
- R7: rsp_done pulses for one cycle after the final selector transfer completes. rsp_rdata then holds the target read data for a read and zero for a write.
- R8: Only one request is in flight. req_ready is low from the cycle after acceptance through the rsp_done cycle, and a request presented during rsp_done is accepted only in a later cycle.
- R9: bus_valid, bus_write, bus_addr and bus_wdata stay unchanged until bus_ready is seen. The block moves to the next transfer only on the cycle in which bus_valid and bus_ready are both high.
- R10: The target write transfer carries req_wdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Address of the replicated register |
| req_group | input | GRP_W | Group to steer to |
| req_inst | input | INST_W | Instance to steer to |
| req_wdata | input | DATA_W | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read result, zero after a write |
| bus_valid | output | 1 | Bus transfer request |
| bus_ready | input | 1 | Slave completes the transfer |
| bus_write | output | 1 | Transfer direction |
| bus_addr | output | ADDR_W | Transfer address |
| bus_wdata | output | DATA_W | Transfer write data |
| bus_rdata | input | DATA_W | Slave read data, valid with bus_ready |

## Verification
Two events can fall in the same cycle: the completion pulse and a new request waiting at the request port. The bench raises req_valid during the rsp_done cycle itself. It then checks that req_ready is low in that cycle and that the held request later runs its full four-transfer sequence with the correct steering values. A second overlap, a slave that answers in the same cycle it sees bus_valid, is exercised with zero-wait runs mixed among random wait states.

// File: rtl/sas_pkg.sv
package sas_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_SEL_RD = 3'd1,
      ST_SEL_WR = 3'd2,
      ST_ACCESS = 3'd3,
      ST_SEL_RS = 3'd4,
      ST_DONE   = 3'd5
   } sas_state_e;

endpackage

// File: rtl/sas_field_merge.sv
module sas_field_merge #(
   parameter int DATA_W   = 32,
   parameter int GRP_W    = 4,
   parameter int GRP_LSB  = 8,
   parameter int INST_W   = 4,
   parameter int INST_LSB = 0,
   parameter bit MC_EN    = 1'b1,
   parameter int MC_BIT   = 16
) (
   input  logic              is_write,
   input  logic [GRP_W-1:0]  group,
   input  logic [INST_W-1:0] inst,
   input  logic [DATA_W-1:0] saved,
   output logic [DATA_W-1:0] steer_val,
   output logic [DATA_W-1:0] restore_val
);

   localparam logic [DATA_W-1:0] GRP_MASK  = DATA_W'({GRP_W{1'b1}})  << GRP_LSB;
   localparam logic [DATA_W-1:0] INST_MASK = DATA_W'({INST_W{1'b1}}) << INST_LSB;

   logic [DATA_W-1:0] mc_mask;
   logic [DATA_W-1:0] mask;
   logic [DATA_W-1:0] fields;

   generate
      if (MC_EN) begin : g_mc
         // multicast flag joins the mask only for writes
         assign mc_mask = DATA_W'(is_write) << MC_BIT;
      end else begin : g_no_mc
         logic unused_wr;
         assign unused_wr = is_write;
         assign mc_mask   = '0;
      end
   endgenerate

   assign mask   = GRP_MASK | INST_MASK | mc_mask;
   assign fields = (DATA_W'(group) << GRP_LSB) | (DATA_W'(inst) << INST_LSB);

   assign steer_val   = (saved & ~mask) | fields;
   assign restore_val = (steer_val & ~mask) | (saved & mask);

endmodule

// File: rtl/sas_ctrl.sv
module sas_ctrl
   import sas_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic       bus_ready,
   output logic       req_ready,
   output logic       req_fire,
   output logic       bus_valid,
   output logic       rsp_done,
   output sas_state_e state_q
);

   sas_state_e state_d;
   logic       xfer_ok;

   assign req_ready = (state_q == ST_IDLE);
   assign req_fire  = req_ready & req_valid;
   assign bus_valid = (state_q == ST_SEL_RD) || (state_q == ST_SEL_WR) ||
                      (state_q == ST_ACCESS) || (state_q == ST_SEL_RS);
   assign xfer_ok   = bus_valid & bus_ready;
   assign rsp_done  = (state_q == ST_DONE);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:   if (req_fire) state_d = ST_SEL_RD;
         ST_SEL_RD: if (xfer_ok)  state_d = ST_SEL_WR;
         ST_SEL_WR: if (xfer_ok)  state_d = ST_ACCESS;
         ST_ACCESS: if (xfer_ok)  state_d = ST_SEL_RS;
         ST_SEL_RS: if (xfer_ok)  state_d = ST_DONE;
         ST_DONE:                 state_d = ST_IDLE;
         default:                 state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

endmodule

// File: rtl/sas_datapath.sv
module sas_datapath
   import sas_pkg::*;
#(
   parameter int              ADDR_W   = 16,
   parameter int              DATA_W   = 32,
   parameter int              GRP_W    = 4,
   parameter int              GRP_LSB  = 8,
   parameter int              INST_W   = 4,
   parameter int              INST_LSB = 0,
   parameter bit              MC_EN    = 1'b1,
   parameter int              MC_BIT   = 16,
   parameter logic [ADDR_W-1:0] SEL_ADDR = 16'h0FD0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  sas_state_e        state_q,
   input  logic              req_fire,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [GRP_W-1:0]  req_group,
   input  logic [INST_W-1:0] req_inst,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              bus_ready,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              bus_write,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] rsp_rdata
);

   logic              op_wr_q;
   logic [ADDR_W-1:0] addr_q;
   logic [GRP_W-1:0]  grp_q;
   logic [INST_W-1:0] inst_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] saved_q;
   logic [DATA_W-1:0] rdata_q;
   logic [DATA_W-1:0] steer_val;
   logic [DATA_W-1:0] restore_val;

   sas_field_merge #(
      .DATA_W  (DATA_W),
      .GRP_W   (GRP_W),
      .GRP_LSB (GRP_LSB),
      .INST_W  (INST_W),
      .INST_LSB(INST_LSB),
      .MC_EN   (MC_EN),
      .MC_BIT  (MC_BIT)
   ) u_merge (
      .is_write   (op_wr_q),
      .group      (grp_q),
      .inst       (inst_q),
      .saved      (saved_q),
      .steer_val  (steer_val),
      .restore_val(restore_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_wr_q <= 1'b0;
         addr_q  <= '0;
         grp_q   <= '0;
         inst_q  <= '0;
         wdata_q <= '0;
      end else if (req_fire) begin
         op_wr_q <= req_write;
         addr_q  <= req_addr;
         grp_q   <= req_group;
         inst_q  <= req_inst;
         wdata_q <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         saved_q <= '0;
         rdata_q <= '0;
      end else begin
         if (state_q == ST_SEL_RD && bus_ready) saved_q <= bus_rdata;
         if (state_q == ST_ACCESS && bus_ready) rdata_q <= op_wr_q ? '0 : bus_rdata;
      end
   end

   always_comb begin
      bus_write = 1'b0;
      bus_addr  = SEL_ADDR;
      bus_wdata = '0;
      unique case (state_q)
         ST_SEL_WR: begin
            bus_write = 1'b1;
            bus_wdata = steer_val;
         end
         ST_ACCESS: begin
            bus_write = op_wr_q;
            bus_addr  = addr_q;
            bus_wdata = op_wr_q ? wdata_q : '0;
         end
         ST_SEL_RS: begin
            bus_write = 1'b1;
            bus_wdata = restore_val;
         end
         default: ;
      endcase
   end

   assign rsp_rdata = rdata_q;

endmodule

// File: rtl/steered_access_seq.sv
module steered_access_seq
   import sas_pkg::*;
#(
   parameter int                ADDR_W   = 16,
   parameter int                DATA_W   = 32,
   parameter int                GRP_W    = 4,
   parameter int                GRP_LSB  = 8,
   parameter int                INST_W   = 4,
   parameter int                INST_LSB = 0,
   parameter bit                MC_EN    = 1'b1,
   parameter int                MC_BIT   = 16,
   parameter logic [ADDR_W-1:0] SEL_ADDR = 16'h0FD0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [GRP_W-1:0]  req_group,
   input  logic [INST_W-1:0] req_inst,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_done,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              bus_valid,
   input  logic              bus_ready,
   output logic              bus_write,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata
);

   // elaboration-time parameter checks
   generate
      if (GRP_LSB + GRP_W > DATA_W) begin : g_bad_grp
         $error("group field exceeds selector width");
      end
      if (INST_LSB + INST_W > DATA_W) begin : g_bad_inst
         $error("instance field exceeds selector width");
      end
      if (GRP_LSB < INST_LSB + INST_W && INST_LSB < GRP_LSB + GRP_W) begin : g_overlap
         $error("group and instance fields overlap");
      end
      if (MC_EN && (MC_BIT >= DATA_W)) begin : g_bad_mc
         $error("multicast flag outside selector");
      end
      if (MC_EN && ((MC_BIT >= GRP_LSB && MC_BIT < GRP_LSB + GRP_W) ||
                    (MC_BIT >= INST_LSB && MC_BIT < INST_LSB + INST_W))) begin : g_mc_clash
         $error("multicast flag inside a steering field");
      end
   endgenerate

   sas_state_e state_q;
   logic       req_fire;

   sas_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_valid(req_valid),
      .bus_ready(bus_ready),
      .req_ready(req_ready),
      .req_fire (req_fire),
      .bus_valid(bus_valid),
      .rsp_done (rsp_done),
      .state_q  (state_q)
   );

   sas_datapath #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .GRP_W   (GRP_W),
      .GRP_LSB (GRP_LSB),
      .INST_W  (INST_W),
      .INST_LSB(INST_LSB),
      .MC_EN   (MC_EN),
      .MC_BIT  (MC_BIT),
      .SEL_ADDR(SEL_ADDR)
   ) u_dp (
      .clk      (clk),
      .rst_n    (rst_n),
      .state_q  (state_q),
      .req_fire (req_fire),
      .req_write(req_write),
      .req_addr (req_addr),
      .req_group(req_group),
      .req_inst (req_inst),
      .req_wdata(req_wdata),
      .bus_ready(bus_ready),
      .bus_rdata(bus_rdata),
      .bus_write(bus_write),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .rsp_rdata(rsp_rdata)
   );

endmodule

// File: rtl/sas_chk.sv
module sas_chk #(
   parameter int                ADDR_W   = 16,
   parameter int                DATA_W   = 32,
   parameter logic [ADDR_W-1:0] SEL_ADDR = 16'h0FD0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              req_write,
   input logic              rsp_done,
   input logic [DATA_W-1:0] rsp_rdata,
   input logic              bus_valid,
   input logic              bus_ready,
   input logic              bus_write,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata
);

   logic last_wr;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      last_wr <= 1'b0;
      else if (req_valid && req_ready) last_wr <= req_write;
   end

   // R2
   first_is_sel_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (bus_valid && !bus_write && bus_addr == SEL_ADDR));

   // R8
   no_accept_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> !req_ready);

   // R8
   idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !bus_valid);

   // R9
   hold_until_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_ready) |=>
         (bus_valid && $stable(bus_write) && $stable(bus_addr) && $stable(bus_wdata)));

   // R7
   single_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   // R7
   write_reports_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && last_wr) |-> (rsp_rdata == '0));

endmodule

bind steered_access_seq sas_chk #(
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .SEL_ADDR(SEL_ADDR)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_valid(req_valid),
   .req_ready(req_ready),
   .req_write(req_write),
   .rsp_done (rsp_done),
   .rsp_rdata(rsp_rdata),
   .bus_valid(bus_valid),
   .bus_ready(bus_ready),
   .bus_write(bus_write),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata)
);

// File: tb/steered_access_seq_tb.sv
module steered_access_seq_tb;

   localparam logic [15:0] SEL = 16'h0FD0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [15:0] req_addr = '0;
   logic [3:0]  req_group = '0;
   logic [3:0]  req_inst = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_done;
   logic [31:0] rsp_rdata;
   logic        bus_valid;
   logic        bus_ready = 1'b0;
   logic        bus_write;
   logic [15:0] bus_addr;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata = '0;

   always #4 clk = ~clk;

   steered_access_seq u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_group(req_group), .req_inst(req_inst),
      .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
      .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit zero_wait = 1'b0;

   // slave model state
   logic [31:0] sel_q = 32'h0;
   int          wcnt = 0;
   int          lg_n = 0;
   logic [15:0] lg_addr [8];
   logic        lg_wr   [8];
   logic [31:0] lg_data [8];

   function automatic logic [31:0] tgt_val(logic [15:0] a, logic [31:0] s);
      return {a, 16'h0} ^ s ^ 32'h5A5A_C3C3;
   endfunction

   function automatic logic [31:0] exp_mask(logic wr);
      return 32'h0000_0F0F | (wr ? 32'h0001_0000 : 32'h0);
   endfunction

   function automatic int next_wait();
      return zero_wait ? 0 : int'($urandom % 4);
   endfunction

   task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // bus slave, driven away from the active edge
   initial begin
      forever begin
         @(negedge clk);
         if (bus_ready) bus_ready = 1'b0;
         else if (bus_valid) begin
            if (wcnt > 0) wcnt--;
            else begin
               if (lg_n < 8) begin
                  lg_addr[lg_n] = bus_addr;
                  lg_wr[lg_n]   = bus_write;
               end
               if (bus_write) begin
                  if (bus_addr == SEL) sel_q = bus_wdata;
                  if (lg_n < 8) lg_data[lg_n] = bus_wdata;
               end else begin
                  bus_rdata = (bus_addr == SEL) ? sel_q : tgt_val(bus_addr, sel_q);
                  if (lg_n < 8) lg_data[lg_n] = bus_rdata;
               end
               lg_n++;
               bus_ready = 1'b1;
               wcnt = next_wait();
            end
         end
      end
   end

   task automatic print_summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired R2 actual=%h expected=%h", 32'h0, 32'h1);
      print_summary();
      $finish;
   end

   // caller is at a negedge; b2b means we are in the rsp_done cycle
   task automatic do_op(logic wr, logic [15:0] a, logic [3:0] g, logic [3:0] i,
                        logic [31:0] wd, logic [31:0] s0, bit b2b);
      logic [31:0] m, mod_e, rst_e, rd_e;
      sel_q = s0;
      lg_n  = 0;
      wcnt  = next_wait();
      m     = exp_mask(wr);
      mod_e = (s0 & ~m) | {20'h0, g, 4'h0, i};
      rst_e = (mod_e & ~m) | (s0 & m);
      rd_e  = wr ? 32'h0 : tgt_val(a, mod_e);
      req_valid = 1'b1; req_write = wr; req_addr = a;
      req_group = g; req_inst = i; req_wdata = wd;
      if (b2b) check(req_ready == 1'b0, "R8 ready low during done", {31'h0, req_ready}, 32'h0);
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      check(req_ready == 1'b0, "R8 ready low while busy", {31'h0, req_ready}, 32'h0);
      while (!rsp_done) @(negedge clk);
      check(lg_n == 4, "R2 transfer count", lg_n, 4);
      check(lg_addr[0] == SEL && !lg_wr[0], "R2 first is selector read",
            {lg_wr[0], 15'h0, lg_addr[0]}, {16'h0, SEL});
      check(lg_addr[1] == SEL && lg_wr[1], "R2 second is selector write",
            {lg_wr[1], 15'h0, lg_addr[1]}, {16'h8000, SEL});
      check(lg_data[1] == mod_e, "R3 steer value", lg_data[1], mod_e);
      if (wr) check(lg_data[1][16] == 1'b0, "R4 multicast cleared", lg_data[1], mod_e);
      else    check(lg_data[1][16] == s0[16], "R5 multicast kept", lg_data[1], mod_e);
      check(lg_addr[2] == a && lg_wr[2] == wr, "R2 target access",
            {lg_wr[2], 15'h0, lg_addr[2]}, {wr, 15'h0, a});
      if (wr) check(lg_data[2] == wd, "R10 target write data", lg_data[2], wd);
      check(lg_addr[3] == SEL && lg_wr[3], "R2 fourth is selector write",
            {lg_wr[3], 15'h0, lg_addr[3]}, {16'h8000, SEL});
      check(lg_data[3] == rst_e, "R6 restore value", lg_data[3], rst_e);
      check(sel_q == s0, "R6 selector unchanged", sel_q, s0);
      check(rsp_rdata == rd_e, "R7 response data", rsp_rdata, rd_e);
   endtask

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      check(req_ready == 1'b1 && bus_valid == 1'b0 && rsp_done == 1'b0, "R1 reset state",
            {29'h0, req_ready, bus_valid, rsp_done}, 32'h4);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready == 1'b1 && bus_valid == 1'b0, "R1 idle after reset",
            {30'h0, req_ready, bus_valid}, 32'h2);

      // directed corners
      do_op(1'b1, 16'h1234, 4'hF, 4'hF, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 1'b0);
      @(negedge clk);
      do_op(1'b0, 16'h2000, 4'h0, 4'h0, 32'h0, 32'h0000_0000, 1'b0);
      @(negedge clk);
      do_op(1'b0, 16'h3004, 4'h5, 4'hA, 32'h0, 32'hFFFF_FFFF, 1'b0);
      zero_wait = 1'b1;
      @(negedge clk);
      do_op(1'b1, 16'h0100, 4'h3, 4'h1, 32'h1111_2222, 32'h0001_0A05, 1'b0);
      // request presented in the done cycle (R8)
      do_op(1'b0, 16'h0200, 4'hC, 4'h7, 32'h0, 32'h8001_F0F0, 1'b1);
      zero_wait = 1'b0;
      do_op(1'b1, 16'h0300, 4'h9, 4'h2, 32'hCAFE_F00D, 32'h0001_0000, 1'b1);

      // constrained random
      for (int k = 0; k < 40; k++) begin
         logic [31:0] s0;
         zero_wait = ($urandom % 5) == 0;
         s0 = $urandom;
         if (($urandom % 8) == 0) s0 = 32'hFFFF_FFFF;
         if (($urandom % 2) == 1'b0) @(negedge clk);
         do_op(1'($urandom % 2), 16'($urandom) & 16'hFFF0 | 16'h0004,
               4'($urandom), 4'($urandom), $urandom, s0, rsp_done);
      end

      repeat (3) @(negedge clk);
      check(req_ready == 1'b1 && bus_valid == 1'b0, "R1 idle at end",
            {30'h0, req_ready, bus_valid}, 32'h2);
      print_summary();
      $finish;
   end

endmodule